// File: doc/BRIEF.md
# Serial ADC Control and Readout Port

This block is the digital slave side of a 14-bit multichannel successive-approximation converter with a serial port. While the active-low chip select is held low, it watches the serial data input on rising serial-clock edges for a start bit. It then collects the rest of an eight-bit control word and decodes from it the channel number, the single-ended/differential choice, the output coding and the clock mode. It runs the bit-by-bit conversion and drives a status strobe. The result leaves on the serial output, most significant bit first, with each bit changing on a falling serial-clock edge.

The analog front end is replaced by an ideal digital comparator that works on a sampled 14-bit level, `sampleIn`. The level is held when the control word completes. In external-clock mode the serial clock paces the comparator decisions. In internal-clock mode a divided system clock paces them, the result is stored, and the host reads it back later. Raising chip select clears any frame in progress, and an internal conversion is abandoned. Every frame ends by itself, so a run of zero bits always returns the start detector to its hunting state.

Every pin is sampled with the 50 MHz system clock `clk`. The high-impedance state of each output is shown by a separate enable signal.

Top module: `sar_adc_serial_port`

## Requirements
- R1: After reset the block is in internal-clock mode: `sstrb` is 1 and `sstrbEn` is 1, `dout` is 0, `chanSel` is 0 and `singleEnded` is 1.
- R2: With `csN` low, the first 1 sampled on `din` at a rising `sclk` edge is the start bit. Zeros before it are ignored. The next seven rising edges supply, in this order, channel bits 2..0, the coding bit (1 = unipolar), the input bit (1 = single-ended), then mode bits M1 and M0. `chanSel` and `singleEnded` take the new values once the last bit is in.
- R3: Mode M1M0 = 11 selects external clock. `sstrb` is 1 after falling edges 8 and 9 of the frame and 0 from falling edge 10 on. The start bit arrives at rising edge 1.
- R4: In external-clock mode, falling edges 10 through 23 put result bits 13 down to 0 on `dout`. After falling edge 24 `dout` is 0 and the port hunts for a new start bit.
- R5: While `csN` is high, `doutEn` is 0 in both modes, and `sstrbEn` is 0 in external-clock mode.
- R6: M1M0 = 10 selects internal clock. `sstrb` drops once the last control bit has been sampled. It rises again after at most (14+1)*INT_DIV system-clock cycles.
- R7: In internal-clock mode, after `sstrb` rises, the first falling edge leaves `dout` at 0. Falling edges 2 through 15 give result bits 13 down to 0, and falling edge 16 returns `dout` to 0 and ends the frame.
- R8: In internal-clock mode, `sstrb` stays driven (`sstrbEn` = 1) and high while `csN` is high.
- R9: Raising `csN` during an internal conversion aborts it. `sstrb` returns high within a few cycles, and later `sclk` pulses with zero data produce no result bits.
- R10: With the coding bit at 1 the result equals the sample (straight binary). With it at 0 the result is the sample with bit 13 inverted (two's complement about mid-scale).
- R11: A control word with M1 = 0 starts no conversion. `sstrb` stays high and `chanSel` keeps its previous value.
- R12: After a frame is abandoned at any point with `csN` low, 18 `sclk` periods with `din` at 0 leave the port ready, and the next control word converts correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; also the base of the internal conversion clock |
| rstN | input | 1 | Asynchronous active-low reset |
| csN | input | 1 | Active-low chip select |
| sclk | input | 1 | Serial clock from the host |
| din | input | 1 | Serial control data, sampled on rising `sclk` |
| sampleIn | input | 14 | Ideal sampled input level for the comparator model |
| dout | output | 1 | Serial result data, changes on falling `sclk` |
| doutEn | output | 1 | 1 when `dout` is driven, 0 for high impedance |
| sstrb | output | 1 | Conversion status strobe |
| sstrbEn | output | 1 | 1 when `sstrb` is driven, 0 for high impedance |
| chanSel | output | 3 | Selected input channel for the front end |
| singleEnded | output | 1 | 1 for single-ended input, 0 for differential |

## Verification
The checks assume that the host holds `sclk` low for the whole internal conversion and never raises `csN` less than a few system clocks after its last serial edge. They also assume `sclk` phases several `clk` cycles long, so that each edge is seen once after synchronisation. The bench keeps every `sclk` phase at eight system clocks and changes `din` only while `sclk` is low. It leaves `sclk` idle until `sstrb` rises in internal mode, and it lets several cycles pass after a frame ends before it moves `csN`.

// File: rtl/sar_adc_pkg.sv
package sar_adc_pkg;

  // control word width and field positions once all but the final bit are in
  localparam int CTRL_BITS = 8;
  localparam int SEL_HI    = 5;
  localparam int SEL_LO    = 3;
  localparam int UNI_POS   = 2;
  localparam int SGL_POS   = 1;
  localparam int M1_POS    = 0;

  typedef struct packed {
    logic shiftCtrl;
    logic ctrlBit;
    logic capture;
    logic sarStep;
    logic emitSar;
    logic loadShift;
    logic emitShift;
    logic clrOut;
  } sarStb_t;

  typedef enum logic [2:0] {
    ST_HUNT,
    ST_CTRL,
    ST_EXT,
    ST_ICONV,
    ST_IREAD
  } portState_t;

endpackage

// File: rtl/sar_adc_ctrl.sv
module sar_adc_ctrl
  import sar_adc_pkg::*;
#(
  parameter int BITS    = 14,
  parameter int INT_DIV = 4
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    csNIn,
  input  logic    sclkIn,
  input  logic    dinIn,
  input  logic    ctrlM1,
  output sarStb_t stb,
  output logic    modeExt,
  output logic    sstrb
);

  localparam int EXT_FIRST = CTRL_BITS + 2;
  localparam int EXT_LAST  = EXT_FIRST + BITS - 1;
  localparam int EXT_END   = EXT_LAST + 1;
  localparam int CNT_W     = $clog2(EXT_END + 1);
  localparam int DIV_W     = $clog2(INT_DIV) + 1;
  localparam int STEP_W    = $clog2(BITS + 1);

  logic [2:0] sclkSh;
  logic [1:0] csSh;
  logic [1:0] dinSh;
  logic       sclkRise;
  logic       sclkFall;
  logic       csHigh;
  logic       dinBit;

  portState_t        state;
  logic [CNT_W-1:0]  cnt;
  logic [DIV_W-1:0]  divCnt;
  logic [STEP_W-1:0] stepCnt;
  logic              extPulse;
  logic              convBusy;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclkSh <= '0;
      csSh   <= '1;
      dinSh  <= '0;
    end else begin
      sclkSh <= {sclkSh[1:0], sclkIn};
      csSh   <= {csSh[0], csNIn};
      dinSh  <= {dinSh[0], dinIn};
    end
  end

  assign sclkRise = sclkSh[1] & ~sclkSh[2];
  assign sclkFall = ~sclkSh[1] & sclkSh[2];
  assign csHigh   = csSh[1];
  assign dinBit   = dinSh[1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_HUNT;
      cnt      <= '0;
      divCnt   <= '0;
      stepCnt  <= '0;
      extPulse <= 1'b0;
      convBusy <= 1'b0;
      modeExt  <= 1'b0;
      stb      <= '0;
    end else begin
      stb <= '0;
      if (csHigh) begin
        state     <= ST_HUNT;
        extPulse  <= 1'b0;
        convBusy  <= 1'b0;
        stb.clrOut <= 1'b1;
      end else begin
        case (state)
          ST_HUNT: begin
            if (sclkRise && dinBit) begin
              stb.shiftCtrl <= 1'b1;
              stb.ctrlBit   <= 1'b1;
              cnt           <= CNT_W'(1);
              state         <= ST_CTRL;
            end
          end
          ST_CTRL: begin
            if (sclkRise) begin
              stb.shiftCtrl <= 1'b1;
              stb.ctrlBit   <= dinBit;
              cnt           <= cnt + 1'b1;
              if (cnt == CNT_W'(CTRL_BITS - 1)) begin
                if (!ctrlM1) begin
                  state <= ST_HUNT;
                end else begin
                  stb.capture <= 1'b1;
                  modeExt     <= dinBit;
                  cnt         <= CNT_W'(CTRL_BITS);
                  if (dinBit) begin
                    state <= ST_EXT;
                  end else begin
                    state    <= ST_ICONV;
                    convBusy <= 1'b1;
                    divCnt   <= '0;
                    stepCnt  <= '0;
                  end
                end
              end
            end
          end
          ST_EXT: begin
            if (sclkFall) begin
              cnt <= cnt + 1'b1;
              if (cnt == CNT_W'(CTRL_BITS)) extPulse <= 1'b1;
              if (cnt == CNT_W'(EXT_FIRST)) extPulse <= 1'b0;
              if (cnt >= CNT_W'(EXT_FIRST) && cnt <= CNT_W'(EXT_LAST)) begin
                stb.sarStep <= 1'b1;
                stb.emitSar <= 1'b1;
              end
              if (cnt == CNT_W'(EXT_END)) begin
                stb.clrOut <= 1'b1;
                state      <= ST_HUNT;
              end
            end
          end
          ST_ICONV: begin
            if (divCnt == DIV_W'(INT_DIV - 1)) begin
              divCnt <= '0;
              if (stepCnt == STEP_W'(BITS)) begin
                stb.loadShift <= 1'b1;
                convBusy      <= 1'b0;
                cnt           <= '0;
                state         <= ST_IREAD;
              end else begin
                stb.sarStep <= 1'b1;
                stepCnt     <= stepCnt + 1'b1;
              end
            end else begin
              divCnt <= divCnt + 1'b1;
            end
          end
          ST_IREAD: begin
            if (sclkFall) begin
              cnt <= cnt + 1'b1;
              if (cnt >= CNT_W'(1) && cnt <= CNT_W'(BITS)) stb.emitShift <= 1'b1;
              if (cnt == CNT_W'(BITS + 1)) begin
                stb.clrOut <= 1'b1;
                state      <= ST_HUNT;
              end
            end
          end
          default: state <= ST_HUNT;
        endcase
      end
    end
  end

  assign sstrb = modeExt ? extPulse : ~convBusy;

endmodule

// File: rtl/sar_adc_datapath.sv
module sar_adc_datapath
  import sar_adc_pkg::*;
#(
  parameter int BITS = 14
) (
  input  logic            clk,
  input  logic            rstN,
  input  sarStb_t         stb,
  input  logic [BITS-1:0] sampleIn,
  output logic            ctrlM1,
  output logic            dout,
  output logic [2:0]      chanSel,
  output logic            singleEnded
);

  logic [CTRL_BITS-1:0] ctrlReg;
  logic [BITS-1:0]      heldVal;
  logic [BITS-1:0]      sarCode;
  logic [BITS-1:0]      trialMask;
  logic [BITS-1:0]      shiftReg;
  logic [BITS-1:0]      trialCode;
  logic                 bipolar;
  logic                 keepBit;
  logic                 decidedBit;

  assign trialCode  = sarCode | trialMask;
  assign keepBit    = (trialCode <= heldVal);
  assign decidedBit = keepBit ^ (bipolar & trialMask[BITS-1]);
  assign ctrlM1     = ctrlReg[M1_POS];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlReg     <= '0;
      heldVal     <= '0;
      sarCode     <= '0;
      trialMask   <= '0;
      shiftReg    <= '0;
      bipolar     <= 1'b0;
      dout        <= 1'b0;
      chanSel     <= '0;
      singleEnded <= 1'b1;
    end else begin
      if (stb.shiftCtrl) ctrlReg <= {ctrlReg[CTRL_BITS-2:0], stb.ctrlBit};
      if (stb.capture) begin
        heldVal     <= sampleIn;
        sarCode     <= '0;
        trialMask   <= {1'b1, {(BITS-1){1'b0}}};
        bipolar     <= ~ctrlReg[UNI_POS];
        chanSel     <= ctrlReg[SEL_HI:SEL_LO];
        singleEnded <= ctrlReg[SGL_POS];
        dout        <= 1'b0;
      end
      if (stb.sarStep) begin
        if (keepBit) sarCode <= trialCode;
        trialMask <= trialMask >> 1;
      end
      if (stb.emitSar) dout <= decidedBit;
      if (stb.loadShift) shiftReg <= sarCode ^ {bipolar, {(BITS-1){1'b0}}};
      if (stb.emitShift) begin
        dout     <= shiftReg[BITS-1];
        shiftReg <= shiftReg << 1;
      end
      if (stb.clrOut) dout <= 1'b0;
    end
  end

endmodule

// File: rtl/sar_adc_serial_port.sv
module sar_adc_serial_port
  import sar_adc_pkg::*;
#(
  parameter int BITS    = 14,
  parameter int INT_DIV = 4
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            csN,
  input  logic            sclk,
  input  logic            din,
  input  logic [BITS-1:0] sampleIn,
  output logic            dout,
  output logic            doutEn,
  output logic            sstrb,
  output logic            sstrbEn,
  output logic [2:0]      chanSel,
  output logic            singleEnded
);

  sarStb_t stb;
  logic    ctrlM1;
  logic    modeExt;

  sar_adc_ctrl #(.BITS(BITS), .INT_DIV(INT_DIV)) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .csNIn   (csN),
    .sclkIn  (sclk),
    .dinIn   (din),
    .ctrlM1  (ctrlM1),
    .stb     (stb),
    .modeExt (modeExt),
    .sstrb   (sstrb)
  );

  sar_adc_datapath #(.BITS(BITS)) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .stb         (stb),
    .sampleIn    (sampleIn),
    .ctrlM1      (ctrlM1),
    .dout        (dout),
    .chanSel     (chanSel),
    .singleEnded (singleEnded)
  );

  assign doutEn  = ~csN;
  assign sstrbEn = ~(modeExt & csN);

endmodule

// File: rtl/sar_adc_serial_port_chk.sv
module sar_adc_serial_port_chk #(
  parameter int BITS    = 14,
  parameter int INT_DIV = 4
) (
  input logic       clk,
  input logic       rstN,
  input logic       csN,
  input logic       dout,
  input logic       doutEn,
  input logic       sstrb,
  input logic       sstrbEn,
  input logic [2:0] chanSel,
  input logic       modeExt
);

  localparam int CONV_MAX = (BITS + 1) * INT_DIV + 2;

  logic [15:0] lowCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) lowCnt <= '0;
    else if (!modeExt && !sstrb) lowCnt <= lowCnt + 1'b1;
    else lowCnt <= '0;
  end

  // R5
  dout_hiz_chk: assert property (@(posedge clk) disable iff (!rstN)
    csN |-> !doutEn);

  // R5
  strobe_hiz_chk: assert property (@(posedge clk) disable iff (!rstN)
    (modeExt && csN) |-> !sstrbEn);

  // R8
  strobe_driven_chk: assert property (@(posedge clk) disable iff (!rstN)
    !modeExt |-> sstrbEn);

  // R6
  conv_len_chk: assert property (@(posedge clk) disable iff (!rstN)
    lowCnt <= 16'(CONV_MAX));

  // R6
  quiet_dout_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!modeExt && !sstrb) |-> !dout);

  // R2
  chan_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(chanSel) |-> !csN);

endmodule

bind sar_adc_serial_port sar_adc_serial_port_chk #(.BITS(BITS), .INT_DIV(INT_DIV)) u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .csN     (csN),
  .dout    (dout),
  .doutEn  (doutEn),
  .sstrb   (sstrb),
  .sstrbEn (sstrbEn),
  .chanSel (chanSel),
  .modeExt (modeExt)
);

// File: tb/test_sar_adc_serial_port.sv
module test_sar_adc_serial_port;

  localparam int BITS    = 14;
  localparam int INT_DIV = 4;
  localparam int HALF    = 8;

  typedef struct packed {
    logic [7:0]      ctl;
    logic [BITS-1:0] smp;
    logic [BITS-1:0] exp;
  } vec_t;

  localparam vec_t VECS [8] = '{
    '{8'hBF, 14'h2A5B, 14'h2A5B},
    '{8'hD3, 14'h2A5B, 14'h0A5B},
    '{8'h8E, 14'h3FFF, 14'h3FFF},
    '{8'hF2, 14'h0000, 14'h2000},
    '{8'h97, 14'h2000, 14'h0000},
    '{8'hEA, 14'h0001, 14'h0001},
    '{8'hAF, 14'h1555, 14'h1555},
    '{8'hC6, 14'h1FFF, 14'h3FFF}
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic csN = 1'b1;
  logic sclk = 1'b0;
  logic din = 1'b0;
  logic [BITS-1:0] sampleIn = '0;
  logic dout, doutEn, sstrb, sstrbEn, singleEnded;
  logic [2:0] chanSel;

  int nChecks = 0;
  int nErrors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  sar_adc_serial_port #(.BITS(BITS), .INT_DIV(INT_DIV)) i_sar_adc_serial_port (
    .clk(clk), .rstN(rstN), .csN(csN), .sclk(sclk), .din(din),
    .sampleIn(sampleIn), .dout(dout), .doutEn(doutEn), .sstrb(sstrb),
    .sstrbEn(sstrbEn), .chanSel(chanSel), .singleEnded(singleEnded)
  );

  task automatic chk(input string req, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nErrors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic pulse(input logic b);
    @(negedge clk);
    din  = b;
    repeat (HALF) @(negedge clk);
    sclk = 1'b1;
    repeat (HALF) @(negedge clk);
    sclk = 1'b0;
    repeat (HALF) @(negedge clk);
  endtask

  task automatic sendByte(input logic [7:0] ctl);
    for (int i = 7; i >= 0; i--) pulse(ctl[i]);
  endtask

  task automatic waitReady(output int waited);
    waited = 0;
    while (sstrb !== 1'b1 && waited < 400) begin
      @(negedge clk);
      waited++;
    end
  endtask

  task automatic runFrame(input logic [7:0] ctl, input logic [BITS-1:0] smp,
                          output logic [BITS-1:0] got);
    int waited;
    sampleIn = smp;
    got = '0;
    sendByte(ctl);
    if (ctl[1:0] == 2'b11) begin
      chk("R3 strobe after edge 8", sstrb, 1);
      pulse(1'b0);
      chk("R3 strobe after edge 9", sstrb, 1);
      for (int i = BITS - 1; i >= 0; i--) begin
        pulse(1'b0);
        got[i] = dout;
        if (i == BITS - 1) chk("R3 strobe low at edge 10", sstrb, 0);
      end
      pulse(1'b0);
      chk("R4 dout idle after edge 24", dout, 0);
    end else begin
      chk("R6 strobe low in conversion", sstrb, 0);
      waitReady(waited);
      chk("R6 conversion length bound", int'(waited <= (BITS + 1) * INT_DIV), 1);
      pulse(1'b0);
      chk("R7 first edge leaves dout 0", dout, 0);
      for (int i = BITS - 1; i >= 0; i--) begin
        pulse(1'b0);
        got[i] = dout;
      end
      pulse(1'b0);
      chk("R7 dout idle after edge 16", dout, 0);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nErrors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", nChecks, nErrors);
      $finish;
    end
  end

  initial begin
    logic [BITS-1:0] got;
    int waited;
    int bad;
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 sstrb", sstrb, 1);
    chk("R1 sstrbEn", sstrbEn, 1);
    chk("R1 doutEn", doutEn, 0);
    chk("R1 dout", dout, 0);
    chk("R1 chanSel", chanSel, 0);
    chk("R1 singleEnded", singleEnded, 1);

    csN = 1'b0;
    repeat (4) @(negedge clk);
    chk("R5 doutEn with cs low", doutEn, 1);

    // R2 leading zeros before the start bit are ignored
    for (int i = 0; i < 5; i++) pulse(1'b0);
    runFrame(8'hAF, 14'h0ABC, got);
    chk("R2 result after leading zeros", got, 14'h0ABC);
    chk("R2 chanSel", chanSel, 2);

    // table walk: R4/R7 result, R10 coding, R2 decode
    foreach (VECS[k]) begin
      runFrame(VECS[k].ctl, VECS[k].smp, got);
      if (VECS[k].ctl[1:0] == 2'b11) chk("R4 R10 external result", got, VECS[k].exp);
      else chk("R7 R10 internal result", got, VECS[k].exp);
      chk("R2 chanSel decode", chanSel, VECS[k].ctl[6:4]);
      chk("R2 singleEnded decode", singleEnded, VECS[k].ctl[2]);
    end

    // R5 external mode: both outputs released when cs high
    runFrame(8'hBF, 14'h0123, got);
    csN = 1'b1;
    repeat (6) @(negedge clk);
    chk("R5 sstrbEn external cs high", sstrbEn, 0);
    chk("R5 doutEn external cs high", doutEn, 0);
    csN = 1'b0;
    repeat (6) @(negedge clk);

    // R8 internal mode keeps strobe driven high with cs high
    runFrame(8'h8E, 14'h0456, got);
    csN = 1'b1;
    repeat (6) @(negedge clk);
    chk("R8 sstrbEn internal cs high", sstrbEn, 1);
    chk("R8 sstrb internal cs high", sstrb, 1);
    csN = 1'b0;
    repeat (6) @(negedge clk);

    // R11 power-down word: no conversion, channel kept
    sendByte(8'hDD);
    bad = 0;
    for (int i = 0; i < 80; i++) begin
      @(negedge clk);
      if (sstrb !== 1'b1) bad++;
    end
    chk("R11 sstrb stays high", bad, 0);
    chk("R11 chanSel kept", chanSel, 0);

    // R9 abort an internal conversion
    sampleIn = 14'h3333;
    sendByte(8'h8E);
    chk("R9 conversion running before abort", sstrb, 0);
    csN = 1'b1;
    repeat (6) @(negedge clk);
    chk("R9 sstrb high after abort", sstrb, 1);
    repeat (100) @(negedge clk);
    csN = 1'b0;
    repeat (6) @(negedge clk);
    bad = 0;
    for (int i = 0; i < 16; i++) begin
      pulse(1'b0);
      if (dout !== 1'b0) bad++;
    end
    chk("R9 no data after abort", bad, 0);

    // R12 abandoned external frame, then 18 zeros
    sampleIn = 14'h0777;
    sendByte(8'hBF);
    for (int i = 0; i < 3; i++) pulse(1'b0);
    for (int i = 0; i < 18; i++) pulse(1'b0);
    runFrame(8'h8E, 14'h1234, got);
    chk("R12 recovery after external break", got, 14'h1234);

    // R12 abandoned internal readout, then 18 zeros
    sampleIn = 14'h2222;
    sendByte(8'hC6);
    waitReady(waited);
    for (int i = 0; i < 5; i++) pulse(1'b0);
    for (int i = 0; i < 18; i++) pulse(1'b0);
    runFrame(8'hBF, 14'h0F0F, got);
    chk("R12 recovery after internal break", got, 14'h0F0F);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", nChecks, nErrors);
    $finish;
  end

endmodule